// File: doc/BRIEF.md
# Slave-Serial Configuration Sequencer

This block loads a programmable logic device over a slave-serial link. A single start pulse makes it switch the device supply on, let the supply settle, hold the device's program input low to clear it, and then wait for the device to report that it is ready to be configured. It then shifts a payload of a given number of bytes into the device, one bit per configuration clock pulse. After the payload it keeps issuing clock pulses until the device reports that configuration is complete.

Payload bytes come from an upstream source over a valid/ready handshake. The source can also raise an error flag in place of a byte, which aborts the load. Every wait is bounded. A device that never reports ready, or never reports completion, ends the sequence in a failure state rather than a hang. The settle and program-pulse delays are derived from the system clock frequency, and a simulation override can shorten them. The pass and fail outputs hold until the next start pulse.

Top module: `serial_cfg_loader`

## Requirements
- R1: After reset the outputs are: supply enable low, program strobe `prog_n_o` high, `cclk_o` low, `din_o` low, `src_ready_o` low, and `busy_o`, `ok_o` and `fail_o` all low.
- R2: When a start pulse is accepted, `pwr_en_o` and `busy_o` go high on the next clock edge. `pwr_en_o` then stays high until reset. `prog_n_o` remains high for exactly DELAY clock cycles, where DELAY is `SIM_DELAY_CYC` when that is non-zero and otherwise `CLK_HZ/1000*DELAY_MS`.
- R3: `prog_n_o` is then driven low for exactly DELAY cycles and released high. `cclk_o` stays low for as long as `prog_n_o` is low.
- R4: After the program pulse, `init_i` is sampled once per cycle. If it is seen low on `INIT_POLLS` consecutive cycles, the block enters the fail state after exactly `INIT_POLLS` cycles and issues no `cclk_o` pulse.
- R5: Each payload byte is sent most significant bit first. `din_o` takes its new value while `cclk_o` is low and holds steady while `cclk_o` is high, so the device captures the bit on the rising edge.
- R6: Exactly `byte_len_i` bytes, latched at start, are requested with `src_ready_o` and taken on cycles with `src_ready_o && src_valid_i`. This gives exactly 8 times `byte_len_i` payload pulses. A length of zero sends no payload.
- R7: After the payload, `done_i` is checked before each further `cclk_o` pulse, and the clock data bit is 0 during these pulses. If `done_i` is seen high, the block enters the pass state. If `DONE_PULSES` pulses have been issued and `done_i` is still low, it enters the fail state.
- R8: If `src_err_i` is high on a cycle where `src_ready_o` is high, no further bits are shifted and the block enters the fail state.
- R9: `ok_o` and `fail_o` are never high together. Each holds until the next start pulse, which clears it and restarts the sequence.
- R10: Every high phase and every low phase of `cclk_o` lasts at least `CCLK_HALF` system clock cycles.
- R11: A start pulse that arrives while `busy_o` is high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Start pulse, taken only when not busy |
| byte_len_i | input | LEN_W | Payload length in bytes, latched at start |
| src_data_i | input | 8 | Payload byte from the source |
| src_valid_i | input | 1 | Source byte valid |
| src_err_i | input | 1 | Source error, aborts the load |
| src_ready_o | output | 1 | Block requests a byte |
| pwr_en_o | output | 1 | Device supply enable |
| prog_n_o | output | 1 | Active-low program strobe to the device |
| cclk_o | output | 1 | Configuration clock |
| din_o | output | 1 | Configuration serial data |
| init_i | input | 1 | Device ready-for-data indication |
| done_i | input | 1 | Device configuration-complete indication |
| busy_o | output | 1 | Sequence in progress |
| ok_o | output | 1 | Last sequence succeeded |
| fail_o | output | 1 | Last sequence failed |

## Verification
The bench builds the block with `SIM_DELAY_CYC=20`, `INIT_POLLS=40`, `DONE_PULSES=12`, `CCLK_HALF=2` and `LEN_W=8`. These values shrink the two 50 ms waits and both timeouts to tens of cycles, so one run can measure the exact settle and program-pulse widths. They also let the run hit the ready timeout, the completion timeout and the case where `done_i` arrives on the very last allowed pulse. A device model in the bench captures `din_o` on rising `cclk_o` edges. It compares the captured bits with the bytes it supplied, and it also measures phase widths and counts trailing pulses.

// File: rtl/serial_cfg_pkg.sv
package serial_cfg_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_POWER,
    ST_PROG,
    ST_INIT,
    ST_FETCH,
    ST_SHIFT,
    ST_TRAIL,
    ST_PASS,
    ST_FAIL
  } seq_state_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_LOW,
    PH_HIGH
  } cell_phase_e;

endpackage

// File: rtl/serial_cfg_timer.sv
module serial_cfg_timer #(
  parameter int CYCLES = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic expired_o
);
  localparam int W = (CYCLES > 1) ? $clog2(CYCLES + 1) : 1;

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i) begin
      cnt_d = W'(CYCLES - 1);
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/serial_cfg_cell.sv
module serial_cfg_cell
  import serial_cfg_pkg::*;
#(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go_i,
  input  logic bit_i,
  output logic busy_o,
  output logic end_o,
  output logic cclk_o,
  output logic din_o
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  cell_phase_e ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic din_q, din_d;
  logic last;

  assign last   = (cnt_q == CW'(HALF - 1));
  assign end_o  = (ph_q == PH_HIGH) && last;
  assign busy_o = (ph_q != PH_IDLE);
  assign cclk_o = (ph_q == PH_HIGH);
  assign din_o  = din_q;

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    din_d = din_q;
    case (ph_q)
      PH_LOW: begin
        if (last) begin
          ph_d  = PH_HIGH;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_HIGH: begin
        if (last) begin
          ph_d  = PH_IDLE;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: ;
    endcase
    if (go_i && ((ph_q == PH_IDLE) || end_o)) begin
      ph_d  = PH_LOW;
      cnt_d = '0;
      din_d = bit_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      din_q <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
      din_q <= din_d;
    end
  end

  // R5: data never moves while the clock is high
  assert_din_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cclk_o |-> $stable(din_o));

  // R10: a new cell is only requested when the previous one is idle or ending
  assert_go_aligned_R10: assert property (@(posedge clk) disable iff (!rst_n)
    go_i |-> (!busy_o || end_o));

endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader
  import serial_cfg_pkg::*;
#(
  parameter int CLK_HZ        = 50_000_000,
  parameter int DELAY_MS      = 50,
  parameter int SIM_DELAY_CYC = 0,
  parameter int INIT_POLLS    = 100000,
  parameter int DONE_PULSES   = 100000,
  parameter int CCLK_HALF     = 2,
  parameter int LEN_W         = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [LEN_W-1:0] byte_len_i,
  input  logic [7:0]       src_data_i,
  input  logic             src_valid_i,
  input  logic             src_err_i,
  output logic             src_ready_o,
  output logic             pwr_en_o,
  output logic             prog_n_o,
  output logic             cclk_o,
  output logic             din_o,
  input  logic             init_i,
  input  logic             done_i,
  output logic             busy_o,
  output logic             ok_o,
  output logic             fail_o
);
  localparam int DELAY_CYC = (SIM_DELAY_CYC != 0) ? SIM_DELAY_CYC : (CLK_HZ / 1000) * DELAY_MS;
  localparam int POLL_MAX  = (INIT_POLLS > DONE_PULSES) ? INIT_POLLS : DONE_PULSES;
  localparam int PW        = $clog2(POLL_MAX + 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  seq_state_e state_q, state_d;
  logic             pwr_q, pwr_d;
  logic [LEN_W-1:0] left_q, left_d;
  logic [7:0]       sh_q, sh_d;
  logic [2:0]       bitn_q, bitn_d;
  logic [PW-1:0]    poll_q, poll_d;

  logic tmr_load, tmr_exp;
  logic cell_go, cell_bit, cell_busy, cell_end;

  serial_cfg_timer #(.CYCLES(DELAY_CYC)) u_timer (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load_i   (tmr_load),
    .expired_o(tmr_exp)
  );

  serial_cfg_cell #(.HALF(CCLK_HALF)) u_cell (
    .clk   (clk),
    .rst_n (rst_int_n),
    .go_i  (cell_go),
    .bit_i (cell_bit),
    .busy_o(cell_busy),
    .end_o (cell_end),
    .cclk_o(cclk_o),
    .din_o (din_o)
  );

  always_comb begin
    state_d  = state_q;
    pwr_d    = pwr_q;
    left_d   = left_q;
    sh_d     = sh_q;
    bitn_d   = bitn_q;
    poll_d   = poll_q;
    tmr_load = 1'b0;
    cell_go  = 1'b0;
    cell_bit = 1'b0;
    case (state_q)
      ST_IDLE, ST_PASS, ST_FAIL: begin
        if (start_i) begin
          state_d  = ST_POWER;
          pwr_d    = 1'b1;
          left_d   = byte_len_i;
          tmr_load = 1'b1;
        end
      end
      ST_POWER: begin
        if (tmr_exp) begin
          state_d  = ST_PROG;
          tmr_load = 1'b1;
        end
      end
      ST_PROG: begin
        if (tmr_exp) begin
          state_d = ST_INIT;
          poll_d  = '0;
        end
      end
      ST_INIT: begin
        if (init_i) begin
          poll_d  = '0;
          state_d = (left_q == '0) ? ST_TRAIL : ST_FETCH;
        end else if (poll_q == PW'(INIT_POLLS - 1)) begin
          state_d = ST_FAIL;
        end else begin
          poll_d = poll_q + 1'b1;
        end
      end
      ST_FETCH: begin
        if (src_err_i) begin
          state_d = ST_FAIL;
        end else if (src_valid_i) begin
          cell_go  = 1'b1;
          cell_bit = src_data_i[7];
          sh_d     = {src_data_i[6:0], 1'b0};
          bitn_d   = 3'd7;
          left_d   = left_q - 1'b1;
          state_d  = ST_SHIFT;
        end
      end
      ST_SHIFT: begin
        if (cell_end) begin
          if (bitn_q != 3'd0) begin
            cell_go  = 1'b1;
            cell_bit = sh_q[7];
            sh_d     = {sh_q[6:0], 1'b0};
            bitn_d   = bitn_q - 1'b1;
          end else begin
            state_d = (left_q == '0) ? ST_TRAIL : ST_FETCH;
          end
        end
      end
      ST_TRAIL: begin
        if (!cell_busy) begin
          if (done_i) begin
            state_d = ST_PASS;
          end else if (poll_q == PW'(DONE_PULSES)) begin
            state_d = ST_FAIL;
          end else begin
            cell_go = 1'b1;
            poll_d  = poll_q + 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_IDLE;
      pwr_q   <= 1'b0;
      left_q  <= '0;
      sh_q    <= '0;
      bitn_q  <= '0;
      poll_q  <= '0;
    end else begin
      state_q <= state_d;
      pwr_q   <= pwr_d;
      left_q  <= left_d;
      sh_q    <= sh_d;
      bitn_q  <= bitn_d;
      poll_q  <= poll_d;
    end
  end

  assign pwr_en_o    = pwr_q;
  assign prog_n_o    = (state_q != ST_PROG);
  assign src_ready_o = (state_q == ST_FETCH);
  assign ok_o        = (state_q == ST_PASS);
  assign fail_o      = (state_q == ST_FAIL);
  assign busy_o      = !(state_q inside {ST_IDLE, ST_PASS, ST_FAIL});

  assert_excl_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(ok_o && fail_o));

  assert_fail_hold_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (fail_o && !start_i) |=> fail_o);

  assert_pwr_hold_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    pwr_en_o |=> pwr_en_o);

  assert_quiet_prog_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    !prog_n_o |-> !cclk_o);

  assert_pass_done_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(ok_o) |-> $past(done_i));

  assert_ready_busy_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    src_ready_o |-> (busy_o && !cclk_o));

endmodule

// File: tb/serial_cfg_loader_bench.sv
`timescale 1ns/1ps
module serial_cfg_loader_bench;
  localparam int DLY   = 20;
  localparam int IPOLL = 40;
  localparam int DPULS = 12;
  localparam int HALF  = 2;
  localparam int LW    = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic start_i;
  logic [LW-1:0] byte_len_i;
  logic [7:0] src_data_i;
  logic src_valid_i, src_err_i, src_ready_o;
  logic pwr_en_o, prog_n_o, cclk_o, din_o;
  logic init_i, done_i;
  logic busy_o, ok_o, fail_o;

  always #10 clk = ~clk;

  serial_cfg_loader #(
    .SIM_DELAY_CYC(DLY), .INIT_POLLS(IPOLL), .DONE_PULSES(DPULS),
    .CCLK_HALF(HALF), .LEN_W(LW)
  ) u_serial_cfg_loader (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .byte_len_i(byte_len_i),
    .src_data_i(src_data_i), .src_valid_i(src_valid_i), .src_err_i(src_err_i),
    .src_ready_o(src_ready_o), .pwr_en_o(pwr_en_o), .prog_n_o(prog_n_o),
    .cclk_o(cclk_o), .din_o(din_o), .init_i(init_i), .done_i(done_i),
    .busy_o(busy_o), .ok_o(ok_o), .fail_o(fail_o)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit cond, input string req, input string what, input int act, input int exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // device and source models
  logic [7:0] mem [0:15];
  logic cap [0:255];
  int rises = 0, run_len = 0, done_target = -1, err_at = -1, idx = 0;
  int hi_run = 0, lo_run = 0, min_hi = 1000, min_lo = 1000;
  bit pend = 0;
  logic cclk_prev = 1'b0;

  always @(negedge clk) begin
    if (cclk_o != cclk_prev) begin
      if (cclk_o) begin
        if (lo_run < min_lo) min_lo = lo_run;
        if (rises < 256) cap[rises] = din_o;
        rises++;
        hi_run = 1;
      end else begin
        if (hi_run < min_hi) min_hi = hi_run;
        lo_run = 1;
      end
    end else if (cclk_o) hi_run++;
    else lo_run++;
    cclk_prev = cclk_o;
    done_i = (done_target >= 0) && (rises >= run_len * 8 + done_target);
    if (pend) idx++;
    src_err_i   = (idx == err_at);
    src_valid_i = (idx != err_at);
    src_data_i  = mem[idx % 16];
    pend = src_ready_o && src_valid_i;
  end

  function automatic int bit_mismatch(input int nbytes);
    int m = 0;
    for (int b = 0; b < nbytes; b++)
      for (int i = 0; i < 8; i++)
        if (cap[b * 8 + i] !== mem[b][7 - i]) m++;
    return m;
  endfunction

  // one full load; init_dly/done_aft < 0 means never
  task automatic do_run(input int len, input int init_dly, input int done_aft,
                        input int err_idx, input bit mid_start);
    int n;
    int exp_rises;
    int shifted;
    bit exp_pass;
    @(posedge clk);
    for (int k = 0; k < 16; k++) mem[k] = 8'($urandom);
    run_len = len; done_target = done_aft; err_at = err_idx;
    rises = 0; idx = 0; pend = 0; min_hi = 1000; min_lo = 1000;
    init_i = 1'b0;
    @(negedge clk);
    start_i = 1'b1; byte_len_i = LW'(len);
    @(negedge clk);
    start_i = 1'b0;
    chk(pwr_en_o && busy_o && !ok_o && !fail_o, "R2", "powered and busy after start", int'(pwr_en_o), 1);
    n = 0;
    while (prog_n_o && n < 1000) begin n++; @(negedge clk); end
    chk(n == DLY, "R2", "cycles before program pulse", n, DLY);
    n = 0;
    while (!prog_n_o && n < 1000) begin
      if (cclk_o) chk(0, "R3", "clock during program pulse", 1, 0);
      n++; @(negedge clk);
    end
    chk(n == DLY, "R3", "program pulse width", n, DLY);
    if (init_dly >= 0) begin
      repeat (init_dly) @(negedge clk);
      init_i = 1'b1;
    end
    n = 0;
    while (busy_o && n < 5000) begin
      start_i = (mid_start && n == 10);
      n++; @(negedge clk);
    end
    start_i = 1'b0;
    if (init_dly < 0) begin
      chk(n == IPOLL && fail_o && !ok_o, "R4", "ready timeout cycles", n, IPOLL);
      chk(rises == 0, "R4", "pulses after ready timeout", rises, 0);
    end else if (err_idx >= 0 && err_idx < len) begin
      chk(fail_o && !ok_o, "R8", "fail after source error", int'(fail_o), 1);
      chk(rises == err_idx * 8, "R8", "pulses before source error", rises, err_idx * 8);
      chk(bit_mismatch(err_idx) == 0, "R5", "bits before error", bit_mismatch(err_idx), 0);
    end else begin
      exp_pass  = (done_aft >= 0) && (done_aft <= DPULS);
      exp_rises = len * 8 + (exp_pass ? done_aft : DPULS);
      shifted   = len;
      if (exp_pass) chk(ok_o && !fail_o, "R7", "pass when done seen", int'(ok_o), 1);
      else          chk(fail_o && !ok_o, "R7", "fail on done timeout", int'(fail_o), 1);
      chk(rises == exp_rises, mid_start ? "R11" : "R6", "total clock pulses", rises, exp_rises);
      chk(bit_mismatch(shifted) == 0, "R5", "payload bits msb first", bit_mismatch(shifted), 0);
      for (int t = len * 8; t < rises && t < 256; t++)
        if (cap[t] !== 1'b0) chk(0, "R7", "trailing data bit", 1, 0);
      if (rises > 0) begin
        chk(min_hi >= HALF, "R10", "shortest high phase", min_hi, HALF);
        chk(min_lo >= HALF, "R10", "shortest low phase", min_lo, HALF);
      end
    end
    repeat (6) @(negedge clk);
    chk(!busy_o && (ok_o != fail_o), "R9", "result held", int'(ok_o) + 2 * int'(fail_o), -1);
    chk(pwr_en_o, "R2", "supply stays on", int'(pwr_en_o), 1);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h0c0f_1a57));
    rst_n = 1'b0; start_i = 1'b0; byte_len_i = '0; init_i = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset levels
    chk(!pwr_en_o && prog_n_o && !cclk_o && !din_o, "R1", "pin idle levels", int'(prog_n_o), 1);
    chk(!busy_o && !ok_o && !fail_o && !src_ready_o, "R1", "status idle", int'(busy_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!pwr_en_o && prog_n_o && !cclk_o && !din_o && !busy_o, "R1", "idle after release", int'(pwr_en_o), 0);

    do_run(3, 2, 0, -1, 0);       // done right after payload
    do_run(0, 0, 3, -1, 0);       // R6 zero length
    do_run(2, -1, 0, -1, 0);      // R4 ready timeout
    do_run(2, 1, -1, -1, 0);      // R7 done timeout
    do_run(1, 3, DPULS, -1, 0);   // R7 done on last allowed pulse
    do_run(4, 0, 1, 2, 0);        // R8 error mid payload
    do_run(3, 1, 2, 0, 0);        // R8 error on first byte
    do_run(3, 2, 4, -1, 1);       // R11 start while busy
    for (int r = 0; r < 6; r++)
      do_run(1 + int'($urandom % 6), int'($urandom % 8), int'($urandom % 13), -1, 0);

    // R9 start clears a held result
    @(negedge clk);
    start_i = 1'b1; byte_len_i = LW'(1);
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o && !ok_o && !fail_o, "R9", "start clears result", int'(ok_o) + int'(fail_o), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule